// File: doc/BRIEF.md
# Mode-Selectable Reference Pre-Divider

This block sits in the reference clock domain, between the chosen input reference and the phase detector of a digital PLL. It cuts the reference down to the rate the loop compares against. A two-bit mode selects how the ratio is formed. Two modes lock directly, with a small fixed ratio only for the fastest inputs. One mode divides every supported input down to 8 kHz. The last uses a shared programmable count. A four-bit frequency code names the nominal reference rate, and the block derives the fixed ratio from that code and the mode.

The outputs are a divided clock and a one-cycle tick that marks the edge the phase detector should use. A new configuration is taken only at the end of the current output period, or straight after a synchronous reset, so the divided clock never shows a runt pulse. A code that makes no sense for the selected mode silences both outputs and sets a flag that stays set until reset.

Top module: `ref_prediv`

## Requirements
- R1: Mode `mode_sel` = 2'b00 (direct lock) uses a ratio of 1 for every frequency code except code 14 (155.52 MHz), which uses a ratio of 2. Code 15 is invalid in this mode.
- R2: Mode 2'b11 (alternate direct lock) accepts codes 0..4 (10, 25, 62.5, 125, 156.25 MHz). Their ratios are 2, 5, 2, 4, 5, which bring 62.5/125/156.25 MHz down to 31.25 MHz and 10/25 MHz down to 5 MHz. Codes 5..15 are invalid.
- R3: Mode 2'b01 divides to 8 kHz, with ratio = input rate / 8 kHz. The codes are 2:8 kHz, 3:1.544, 4:2.048, 5:5, 6:6.312, 7:6.48, 8:19.44, 9:25.92, 11:38.88, 12:51.84, 13:77.76, 14:155.52 and 15:25.0 MHz. Code 10 (31.25 MHz) has no integer ratio and is invalid. Codes 0 (2 kHz) and 1 (4 kHz) ignore this mode and use direct lock with ratio 1.
- R4: Mode 2'b10 (programmable) divides by `divn_val`+1 for any `divn_val` from 0 to 65535. Codes 14 and 15 are invalid in this mode.
- R5: While the mode/code pair is invalid, `tick_o` and `div_clk_o` stay low and `config_error_o` is set. The flag stays set after the configuration is corrected and clears only on reset. The first edge after correction loads the new ratio and produces a tick.
- R6: A change of mode, code, `divn_val` or `edge_pol` during a period does not shorten or stretch that period. It applies from the next period. The first clock edge after reset is released starts a period with the current configuration.
- R7: `tick_o` is high for exactly one cycle in every period of R cycles. With R = 1 it is high every cycle.
- R8: Each period begins with the high phase of `div_clk_o`, which lasts floor(R/2) cycles; the low phase lasts the rest. With R = 1, `div_clk_o` stays high.
- R9: In mode 2'b01 with a code of 2 or above, `edge_pol` = 0 places the tick on the first high cycle of `div_clk_o`, and `edge_pol` = 1 places it on the first low cycle. In every other case `edge_pol` is ignored and the tick falls on the first high cycle.
- R10: While `rst_ref` is high, `tick_o`, `div_clk_o` and `config_error_o` are low after the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, the block's only clock |
| rst_ref | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Bit 1 programmable divide, bit 0 divide-to-8 kHz; both set is alternate direct lock |
| freq_code | input | 4 | Nominal reference rate code |
| divn_val | input | 16 | Shared divide count for the programmable mode |
| edge_pol | input | 1 | Tick edge select in the 8 kHz mode |
| div_clk_o | output | 1 | Divided clock |
| tick_o | output | 1 | One-cycle marker of the lock edge |
| config_error_o | output | 1 | Sticky invalid-configuration flag |

## Verification
On every cycle the assertions check four things: the error flag never drops, an invalid cycle leaves the outputs silent on the next one, the loaded ratio holds until the terminal count, and ticks never come back to back within a period. They also check that a rising divided clock in the default polarity carries a tick. The per-code ratios, the exact high-phase length, the tick placement under each polarity, and a change made in the middle of a period without a runt can only be shown by the bench. It measures intervals between ticks against ratios computed from the input frequencies.

// File: rtl/ref_prediv.sv
module ref_prediv #(
  parameter int DIVN_W = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk_ref,
  input  logic              rst_ref,
  input  logic [1:0]        mode_sel,
  input  logic [CODE_W-1:0] freq_code,
  input  logic [DIVN_W-1:0] divn_val,
  input  logic              edge_pol,
  output logic              div_clk_o,
  output logic              tick_o,
  output logic              config_error_o
);
  localparam int CNT_W = DIVN_W + 1;

  logic [CNT_W-1:0] nxt_ratio, ratio_q, cnt_q, hi_len, tick_pos;
  logic             nxt_pol, cfg_bad, pol_q, run_q, err_q;

  always_comb begin
    nxt_ratio = CNT_W'(1);
    nxt_pol   = 1'b0;
    cfg_bad   = 1'b0;
    unique case (mode_sel)
      2'b00: begin
        if (freq_code == CODE_W'(14)) nxt_ratio = CNT_W'(2);
        else if (freq_code == CODE_W'(15)) cfg_bad = 1'b1;
      end
      2'b11: begin
        case (freq_code)
          CODE_W'(0): nxt_ratio = CNT_W'(2);
          CODE_W'(1): nxt_ratio = CNT_W'(5);
          CODE_W'(2): nxt_ratio = CNT_W'(2);
          CODE_W'(3): nxt_ratio = CNT_W'(4);
          CODE_W'(4): nxt_ratio = CNT_W'(5);
          default:    cfg_bad   = 1'b1;
        endcase
      end
      2'b01: begin
        nxt_pol = edge_pol && (freq_code >= CODE_W'(2));
        case (freq_code)
          CODE_W'(3):  nxt_ratio = CNT_W'(193);
          CODE_W'(4):  nxt_ratio = CNT_W'(256);
          CODE_W'(5):  nxt_ratio = CNT_W'(625);
          CODE_W'(6):  nxt_ratio = CNT_W'(789);
          CODE_W'(7):  nxt_ratio = CNT_W'(810);
          CODE_W'(8):  nxt_ratio = CNT_W'(2430);
          CODE_W'(9):  nxt_ratio = CNT_W'(3240);
          CODE_W'(10): cfg_bad   = 1'b1;
          CODE_W'(11): nxt_ratio = CNT_W'(4860);
          CODE_W'(12): nxt_ratio = CNT_W'(6480);
          CODE_W'(13): nxt_ratio = CNT_W'(9720);
          CODE_W'(14): nxt_ratio = CNT_W'(19440);
          CODE_W'(15): nxt_ratio = CNT_W'(3125);
          default:     nxt_ratio = CNT_W'(1);
        endcase
      end
      default: begin
        if (freq_code >= CODE_W'(14)) cfg_bad = 1'b1;
        else nxt_ratio = {1'b0, divn_val} + CNT_W'(1);
      end
    endcase
  end

  always_ff @(posedge clk_ref) begin
    if (rst_ref) begin
      run_q   <= 1'b0;
      err_q   <= 1'b0;
      pol_q   <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= CNT_W'(1);
    end else if (cfg_bad) begin
      err_q <= 1'b1;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q || cnt_q == '0) begin
      run_q   <= 1'b1;
      ratio_q <= nxt_ratio;
      pol_q   <= nxt_pol;
      cnt_q   <= nxt_ratio - CNT_W'(1);
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign hi_len   = (ratio_q == CNT_W'(1)) ? CNT_W'(1) : (ratio_q >> 1);
  assign tick_pos = (pol_q && ratio_q != CNT_W'(1)) ? ratio_q - CNT_W'(1) - hi_len
                                                    : ratio_q - CNT_W'(1);

  assign div_clk_o      = run_q && !cfg_bad && (cnt_q >= ratio_q - hi_len);
  assign tick_o         = run_q && !cfg_bad && (cnt_q == tick_pos);
  assign config_error_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_ref) disable iff (rst_ref)
    config_error_o |=> config_error_o); // R5

  AST_BAD_SILENT: assert property (@(posedge clk_ref) disable iff (rst_ref)
    cfg_bad |=> (!tick_o && !div_clk_o)); // R5

  AST_RATIO_HELD: assert property (@(posedge clk_ref) disable iff (rst_ref)
    (run_q && cnt_q != '0 && !cfg_bad) |=> $stable(ratio_q)); // R6

  AST_ONE_TICK: assert property (@(posedge clk_ref) disable iff (rst_ref)
    (tick_o && ratio_q != CNT_W'(1) && cnt_q != '0) |=> !tick_o); // R7

  AST_RISE_TICK: assert property (@(posedge clk_ref) disable iff (rst_ref)
    (!pol_q && $rose(div_clk_o)) |-> tick_o); // R9
endmodule

// File: tb/tb_ref_prediv.sv
module tb_ref_prediv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [3:0]  code = 4'd0;
  logic [15:0] divn = 16'd0;
  logic        pol = 1'b0;
  logic        div_clk, tick, err;

  always #5 clk = ~clk;

  ref_prediv dut (
    .clk_ref(clk), .rst_ref(rst), .mode_sel(mode), .freq_code(code),
    .divn_val(divn), .edge_pol(pol), .div_clk_o(div_clk), .tick_o(tick),
    .config_error_o(err)
  );

  typedef struct { int iv; int hi; bit dt; string tag; } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, cyc = 0, last = 0, hi_acc = 0;
  bit skip = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int std_hz(input int c);
    case (c)
      0: return 2000;       1: return 4000;       2: return 8000;
      3: return 1544000;    4: return 2048000;    5: return 5000000;
      6: return 6312000;    7: return 6480000;    8: return 19440000;
      9: return 25920000;   10: return 31250000;  11: return 38880000;
      12: return 51840000;  13: return 77760000;  14: return 155520000;
      default: return 25000000;
    endcase
  endfunction

  function automatic int alt_hz(input int c);
    case (c)
      0: return 10000000;  1: return 25000000;  2: return 62500000;
      3: return 125000000; 4: return 156250000; default: return 0;
    endcase
  endfunction

  // returns 0 for an invalid pair
  function automatic int model_ratio(input int m, input int c, input int d);
    int f;
    case (m)
      0: return (c == 15) ? 0 : ((c == 14) ? 2 : 1);
      3: begin
        f = alt_hz(c);
        if (f == 0) return 0;
        return (f >= 31250000) ? f / 31250000 : f / 5000000;
      end
      1: begin
        if (c < 2) return 1;
        f = std_hz(c);
        return (f % 8000 == 0) ? f / 8000 : 0;
      end
      default: return (c >= 14) ? 0 : d + 1;
    endcase
  endfunction

  function automatic exp_t mk(input int r, input bit pe, input string tag);
    exp_t e;
    e.iv = r;
    e.hi = (r == 1) ? 1 : r / 2;
    e.dt = (r == 1) ? 1'b1 : !pe;
    e.tag = tag;
    return e;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_empty();
    while (q.size() > 0) step(1);
  endtask

  task automatic run_cfg(input int m, input int c, input int d, input bit p,
                         input int n, input string tag);
    int r;
    bit pe;
    r  = model_ratio(m, c, d);
    pe = p && (m == 1) && (c >= 2);
    mode = 2'(m); code = 4'(c); divn = 16'(d); pol = p;
    rst = 1'b1;
    step(2);
    skip = 1'b1;
    rst = 1'b0;
    for (int i = 0; i < n; i++) q.push_back(mk(r, pe, tag));
    wait_empty();
  endtask

  task automatic bad_cfg(input int m, input int c, input string tag);
    mode = 2'(m); code = 4'(c);
    step(3);
    chk(err == 1'b1, {tag, " flag"}, err, 1);
    for (int i = 0; i < 10; i++) begin
      step(1);
      chk(!tick && !div_clk, {tag, " silent"}, {tick, div_clk}, 0);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (!rst) begin
      if (tick) begin
        if (skip) skip = 1'b0;
        else if (q.size() > 0) begin
          e = q.pop_front();
          chk(cyc - last == e.iv, {e.tag, " interval"}, cyc - last, e.iv);
          chk(hi_acc == e.hi, {e.tag, " high phase"}, hi_acc, e.hi);
          chk(div_clk == e.dt, {e.tag, " div at tick"}, div_clk, e.dt);
        end
        last = cyc;
        hi_acc = div_clk ? 1 : 0;
      end else if (div_clk) hi_acc++;
    end
  end

  initial begin
    step(3);
    chk(!tick && !div_clk && !err, "R10 reset outputs", {tick, div_clk, err}, 0);

    run_cfg(0, 3, 0, 1'b0, 3, "R1 direct 1.544M");
    run_cfg(0, 14, 0, 1'b1, 3, "R1 R9 direct 155.52M pol ignored");
    for (int c = 0; c < 5; c++) run_cfg(3, c, 0, 1'b0, 3, "R2 alternate");
    run_cfg(1, 3, 0, 1'b0, 2, "R3 8k 1.544M");
    run_cfg(1, 4, 0, 1'b1, 2, "R3 R9 8k 2.048M pol1");
    run_cfg(1, 1, 0, 1'b1, 3, "R3 8k 4k bypass");
    run_cfg(1, 15, 0, 1'b0, 2, "R3 8k 25M");
    run_cfg(1, 14, 0, 1'b0, 1, "R3 8k 155.52M");
    run_cfg(2, 0, 0, 1'b0, 3, "R4 R7 divide by 1");
    run_cfg(2, 5, 4, 1'b0, 3, "R4 R8 odd ratio 5");
    run_cfg(2, 5, 65535, 1'b0, 1, "R4 ratio 65536");

    // R6: change in the middle of a period
    run_cfg(2, 3, 9, 1'b0, 1, "R6 before change");
    q.push_back(mk(10, 1'b0, "R6 period in flight"));
    q.push_back(mk(3, 1'b0, "R6 new ratio"));
    q.push_back(mk(3, 1'b0, "R6 new ratio"));
    step(2);
    divn = 16'd2;
    wait_empty();

    // R5: invalid pairs, sticky flag, resume after correction
    bad_cfg(3, 7, "R5 alternate code 7");
    skip = 1'b1;
    mode = 2'b00; code = 4'd14;
    for (int i = 0; i < 3; i++) q.push_back(mk(2, 1'b0, "R5 resume"));
    wait_empty();
    chk(err == 1'b1, "R5 flag sticky", err, 1);
    bad_cfg(1, 10, "R5 8k code 10");
    bad_cfg(2, 14, "R5 programmable code 14");
    bad_cfg(0, 15, "R5 direct code 15");
    mode = 2'b00; code = 4'd3;
    rst = 1'b1;
    step(2);
    chk(err == 1'b0, "R5 R10 flag cleared by reset", err, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired with %0d expected ticks pending", q.size());
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule